// File: doc/BRIEF.md
# Condition-Code Flow Sequencer

This block drives the program counter of a small vector-program engine. Each cycle in which `issue` is high, the instruction at the current program counter is presented on the inputs. The block then does one of four things. An ordinary instruction advances the counter. A branch jumps to the target when a condition test passes. A call jumps to the target in the same way and saves the return address on a four-entry hardware stack. A return pops the saved address back into the counter.

The tests read a four-component condition-code register. Each component holds one of four states: less than zero, equal to zero, greater than zero, or unordered. Only ordinary instructions that carry the update flag write this register. Flow-control instructions leave it as it is. A counted loop is therefore built from two instructions: a decrement that updates the condition codes, and a branch back to the loop head that is taken while the selected component is greater than zero.

A call into a full stack sets a sticky error, and so does a return from an empty stack. From then on the block is frozen until reset.

Top module: `ccseq_top`

## Requirements
- R1: Synchronous reset sets the counter to 0 and clears the error. It also sets every condition-code component to equal-to-zero, so a test for equality passes on any component right after reset.
- R2: An issued ordinary instruction (op code 0) advances the counter by one. When `cc_wr` is high, each component is written from its 16-bit signed result. A set unordered bit gives unordered (3). Otherwise a negative result gives less-than (1), zero gives equal (0) and a positive result gives greater-than (2). A flow instruction issued in the very next cycle sees the new state.
- R3: The condition codes keep their value when an ordinary instruction is issued with `cc_wr` low. They also keep their value for any branch (1), call (2) or return (3), whatever `cc_wr` and the result inputs hold.
- R4: A branch loads `target` when its test passes on the component selected by `comp_sel`, and otherwise advances by one. The test codes are: 0 always; 1 never; 2 equal; 3 not equal (which is true for unordered); 4 less; 5 greater-or-equal; 6 greater; 7 less-or-equal. Every test other than 0 and 3 fails on unordered.
- R5: A call whose test passes saves the counter plus one and loads `target`. A call whose test fails advances by one and saves nothing.
- R6: A return ignores its test and loads the most recently saved address.
- R7: Calls nest four deep, and the returns come back in last-in, first-out order.
- R8: The error is set in two cases. The first is a passing call made while four addresses are already saved. The second is a return made while none are saved. The counter keeps its value in that cycle, and the error stays set until reset.
- R9: While the error is set, the counter and the condition codes do not change, whatever the inputs hold.
- R10: With `issue` low, the counter and the condition codes hold.
- R11: The 9-bit counter wraps from 511 to 0, both on an ordinary step and in the address that a call saves.
- R12: A loop made of a flagged decrement followed by a greater-than branch back to the decrement runs its body exactly N times for a start count of N. It then leaves at the address after the branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | An instruction is executed this cycle |
| op | input | 2 | 0 ordinary, 1 branch, 2 call, 3 return |
| target | input | 9 | Jump or call destination |
| test_sel | input | 3 | Condition test code |
| comp_sel | input | 2 | Condition-code component tested |
| cc_wr | input | 1 | Update flag of an ordinary instruction |
| res_data | input | 64 | Four 16-bit signed results, component 0 in the low bits |
| res_unord | input | 4 | Per-component unordered flag |
| pc | output | 9 | Program counter |
| stack_err | output | 1 | Sticky stack overflow or underflow |

## Verification
Both the counter and the error flag are registered, so their effect is due at the first rising edge after an issue. The bench drives each instruction at a falling edge and compares both outputs at the next falling edge. A condition-code write takes effect at that same edge. Its result is therefore observed through a branch issued in the following cycle, which shows up on `pc` one more edge later. Each check waits for exactly that edge and never samples earlier.

// File: rtl/ccseq_pkg.sv
package ccseq_pkg;

    localparam int PC_W_DEF   = 9;
    localparam int DEPTH_DEF  = 4;
    localparam int NCOMP_DEF  = 4;
    localparam int RES_W_DEF  = 16;

    typedef enum logic [1:0] {
        OP_PLAIN  = 2'd0,
        OP_BRANCH = 2'd1,
        OP_CALL   = 2'd2,
        OP_RETURN = 2'd3
    } flow_op_e;

    typedef enum logic [1:0] {
        CC_EQ = 2'd0,
        CC_LT = 2'd1,
        CC_GT = 2'd2,
        CC_UN = 2'd3
    } cc_state_e;

    typedef enum logic [2:0] {
        T_ALWAYS = 3'd0,
        T_NEVER  = 3'd1,
        T_EQ     = 3'd2,
        T_NE     = 3'd3,
        T_LT     = 3'd4,
        T_GE     = 3'd5,
        T_GT     = 3'd6,
        T_LE     = 3'd7
    } cc_test_e;

    function automatic logic test_pass(input cc_test_e t, input cc_state_e s);
        logic r;
        case (t)
            T_ALWAYS: r = 1'b1;
            T_NEVER:  r = 1'b0;
            T_EQ:     r = (s == CC_EQ);
            T_NE:     r = (s != CC_EQ);
            T_LT:     r = (s == CC_LT);
            T_GE:     r = (s == CC_GT) || (s == CC_EQ);
            T_GT:     r = (s == CC_GT);
            T_LE:     r = (s == CC_LT) || (s == CC_EQ);
            default:  r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ccseq_ccreg.sv
module ccseq_ccreg
    import ccseq_pkg::*;
#(
    parameter int N_COMP = NCOMP_DEF,
    parameter int RES_W  = RES_W_DEF
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [N_COMP*RES_W-1:0]   res_data,
    input  logic [N_COMP-1:0]         res_unord,
    output logic [2*N_COMP-1:0]       cc_flat
);

    for (genvar i = 0; i < N_COMP; i++) begin : g_comp
        logic signed [RES_W-1:0] val;
        cc_state_e               nxt;
        cc_state_e               st_q;

        assign val = res_data[i*RES_W +: RES_W];

        always_comb begin
            if (res_unord[i])
                nxt = CC_UN;
            else if (val < 0)
                nxt = CC_LT;
            else if (val == '0)
                nxt = CC_EQ;
            else
                nxt = CC_GT;
        end

        always_ff @(posedge clk) begin
            if (rst)
                st_q <= CC_EQ;
            else if (wr_en)
                st_q <= nxt;
        end

        assign cc_flat[2*i +: 2] = st_q;
    end

endmodule

// File: rtl/ccseq_cond.sv
module ccseq_cond
    import ccseq_pkg::*;
#(
    parameter int N_COMP = NCOMP_DEF
) (
    input  logic [2*N_COMP-1:0]          cc_flat,
    input  logic [$clog2(N_COMP)-1:0]    comp_sel,
    input  logic [2:0]                   test_sel,
    output logic                         pass
);

    localparam int SW = $clog2(N_COMP);

    cc_state_e sel_state;

    always_comb begin
        sel_state = CC_EQ;
        for (int i = 0; i < N_COMP; i++) begin
            if (comp_sel == SW'(i))
                sel_state = cc_state_e'(cc_flat[2*i +: 2]);
        end
    end

    assign pass = test_pass(cc_test_e'(test_sel), sel_state);

endmodule

// File: rtl/ccseq_stack.sv
module ccseq_stack #(
    parameter int PC_W  = 9,
    parameter int DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          push,
    input  logic                          pop,
    input  logic [PC_W-1:0]               push_addr,
    output logic [PC_W-1:0]               top_addr,
    output logic                          full,
    output logic                          empty,
    output logic [$clog2(DEPTH+1)-1:0]    depth
);

    localparam int CNT_W = $clog2(DEPTH+1);

    logic [CNT_W-1:0] cnt_q;
    logic [PC_W-1:0]  slots [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [PC_W-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst)
                slot_q <= '0;
            else if (push && cnt_q == CNT_W'(i))
                slot_q <= push_addr;
        end
        assign slots[i] = slot_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (push && !full)
            cnt_q <= cnt_q + CNT_W'(1);
        else if (pop && !empty)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    always_comb begin
        top_addr = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cnt_q == CNT_W'(i + 1))
                top_addr = slots[i];
        end
    end

    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign empty = (cnt_q == '0);
    assign depth = cnt_q;

endmodule

// File: rtl/ccseq_pcgen.sv
module ccseq_pcgen
    import ccseq_pkg::*;
#(
    parameter int PC_W = PC_W_DEF
) (
    input  logic              live,
    input  flow_op_e          op,
    input  logic              pass,
    input  logic              full,
    input  logic              empty,
    input  logic [PC_W-1:0]   pc,
    input  logic [PC_W-1:0]   target,
    input  logic [PC_W-1:0]   ret_addr,
    output logic [PC_W-1:0]   pc_nxt,
    output logic [PC_W-1:0]   link_addr,
    output logic              push,
    output logic              pop,
    output logic              fault,
    output logic              cc_allow
);

    logic [PC_W-1:0] pc_inc;

    assign pc_inc    = pc + PC_W'(1);
    assign link_addr = pc_inc;
    assign cc_allow  = live && (op == OP_PLAIN);

    always_comb begin
        pc_nxt = pc;
        push   = 1'b0;
        pop    = 1'b0;
        fault  = 1'b0;
        if (live) begin
            unique case (op)
                OP_PLAIN: pc_nxt = pc_inc;
                OP_BRANCH: pc_nxt = pass ? target : pc_inc;
                OP_CALL: begin
                    if (!pass)
                        pc_nxt = pc_inc;
                    else if (full)
                        fault = 1'b1;
                    else begin
                        push   = 1'b1;
                        pc_nxt = target;
                    end
                end
                OP_RETURN: begin
                    if (empty)
                        fault = 1'b1;
                    else begin
                        pop    = 1'b1;
                        pc_nxt = ret_addr;
                    end
                end
                default: pc_nxt = pc;
            endcase
        end
    end

endmodule

// File: rtl/ccseq_top.sv
module ccseq_top
    import ccseq_pkg::*;
#(
    parameter int PC_W   = PC_W_DEF,
    parameter int DEPTH  = DEPTH_DEF,
    parameter int N_COMP = NCOMP_DEF,
    parameter int RES_W  = RES_W_DEF
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          issue,
    input  logic [1:0]                    op,
    input  logic [PC_W-1:0]               target,
    input  logic [2:0]                    test_sel,
    input  logic [$clog2(N_COMP)-1:0]     comp_sel,
    input  logic                          cc_wr,
    input  logic [N_COMP*RES_W-1:0]       res_data,
    input  logic [N_COMP-1:0]             res_unord,
    output logic [PC_W-1:0]               pc,
    output logic                          stack_err
);

    localparam int CNT_W = $clog2(DEPTH+1);

    flow_op_e               op_e;
    logic                   live;
    logic                   cond_pass;
    logic [2*N_COMP-1:0]    cc_flat;
    logic                   cc_allow;
    logic                   cc_we;
    logic                   stk_push, stk_pop, stk_full, stk_empty;
    logic [CNT_W-1:0]       stk_depth;
    logic [PC_W-1:0]        ret_addr, link_addr, pc_nxt;
    logic                   fault;
    logic [PC_W-1:0]        pc_q;
    logic                   err_q;

    assign op_e  = flow_op_e'(op);
    assign live  = issue && !err_q;
    assign cc_we = cc_allow && cc_wr;

    ccseq_ccreg #(.N_COMP(N_COMP), .RES_W(RES_W)) u_ccreg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cc_we),
        .res_data  (res_data),
        .res_unord (res_unord),
        .cc_flat   (cc_flat)
    );

    ccseq_cond #(.N_COMP(N_COMP)) u_cond (
        .cc_flat  (cc_flat),
        .comp_sel (comp_sel),
        .test_sel (test_sel),
        .pass     (cond_pass)
    );

    ccseq_stack #(.PC_W(PC_W), .DEPTH(DEPTH)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (stk_push),
        .pop       (stk_pop),
        .push_addr (link_addr),
        .top_addr  (ret_addr),
        .full      (stk_full),
        .empty     (stk_empty),
        .depth     (stk_depth)
    );

    ccseq_pcgen #(.PC_W(PC_W)) u_pcgen (
        .live      (live),
        .op        (op_e),
        .pass      (cond_pass),
        .full      (stk_full),
        .empty     (stk_empty),
        .pc        (pc_q),
        .target    (target),
        .ret_addr  (ret_addr),
        .pc_nxt    (pc_nxt),
        .link_addr (link_addr),
        .push      (stk_push),
        .pop       (stk_pop),
        .fault     (fault),
        .cc_allow  (cc_allow)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            err_q <= 1'b0;
        end else begin
            pc_q <= pc_nxt;
            if (fault)
                err_q <= 1'b1;
        end
    end

    assign pc        = pc_q;
    assign stack_err = err_q;

endmodule

// File: rtl/ccseq_chk.sv
module ccseq_chk
    import ccseq_pkg::*;
#(
    parameter int PC_W   = 9,
    parameter int DEPTH  = 4,
    parameter int N_COMP = 4
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          issue,
    input logic                          cc_wr,
    input logic [1:0]                    op,
    input logic [PC_W-1:0]               target,
    input logic [PC_W-1:0]               pc,
    input logic                          stack_err,
    input logic                          live,
    input logic                          cond_pass,
    input logic                          stk_full,
    input logic [$clog2(DEPTH+1)-1:0]    stk_depth,
    input logic [2*N_COMP-1:0]           cc_flat
);

    localparam int CNT_W = $clog2(DEPTH+1);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (pc == '0 && !stack_err));

    p_plain_step_r2: assert property (@(posedge clk) disable iff (rst)
        (live && op == OP_PLAIN) |=> (pc == $past(pc) + PC_W'(1)));

    p_flow_cc_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (op != OP_PLAIN) |=> $stable(cc_flat));

    p_noflag_cc_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !cc_wr |=> $stable(cc_flat));

    p_branch_taken_r4: assert property (@(posedge clk) disable iff (rst)
        (live && op == OP_BRANCH && cond_pass) |=> (pc == $past(target)));

    p_branch_fall_r4: assert property (@(posedge clk) disable iff (rst)
        (live && op == OP_BRANCH && !cond_pass) |=> (pc == $past(pc) + PC_W'(1)));

    p_depth_bound_r7: assert property (@(posedge clk) disable iff (rst)
        stk_depth <= CNT_W'(DEPTH));

    p_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        (live && op == OP_CALL && cond_pass && stk_full) |=> stack_err);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        stack_err |=> stack_err);

    p_err_freeze_r9: assert property (@(posedge clk) disable iff (rst)
        stack_err |=> ($stable(pc) && $stable(cc_flat)));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !issue |=> ($stable(pc) && $stable(cc_flat)));

endmodule

bind ccseq_top ccseq_chk #(.PC_W(PC_W), .DEPTH(DEPTH), .N_COMP(N_COMP)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .issue     (issue),
    .cc_wr     (cc_wr),
    .op        (op),
    .target    (target),
    .pc        (pc),
    .stack_err (stack_err),
    .live      (live),
    .cond_pass (cond_pass),
    .stk_full  (stk_full),
    .stk_depth (stk_depth),
    .cc_flat   (cc_flat)
);

// File: tb/ccseq_top_bench.sv
module ccseq_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [8:0]  target = '0;
    logic [2:0]  test_sel = '0;
    logic [1:0]  comp_sel = '0;
    logic        cc_wr = 1'b0;
    logic [63:0] res_data = '0;
    logic [3:0]  res_unord = '0;
    logic [8:0]  pc;
    logic        stack_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int m_pc;
    int m_cc [4];
    int m_stk [4];
    int m_sp;
    bit m_err;

    always #10 clk = ~clk;

    ccseq_top u_ccseq_top (
        .clk(clk), .rst(rst), .issue(issue), .op(op), .target(target),
        .test_sel(test_sel), .comp_sel(comp_sel), .cc_wr(cc_wr),
        .res_data(res_data), .res_unord(res_unord), .pc(pc), .stack_err(stack_err)
    );

    function automatic int classify(input int v, input bit u);
        if (u) return 3;
        if (v < 0) return 1;
        if (v == 0) return 0;
        return 2;
    endfunction

    function automatic bit passes(input int t, input int s);
        case (t)
            0: return 1;
            1: return 0;
            2: return s == 0;
            3: return s != 0;
            4: return s == 1;
            5: return s == 2 || s == 0;
            6: return s == 2;
            default: return s == 1 || s == 0;
        endcase
    endfunction

    function automatic logic [63:0] pk(input int a, input int b, input int c, input int d);
        return {16'(d), 16'(c), 16'(b), 16'(a)};
    endfunction

    task automatic check_val(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run(input int o, input int tgt, input int tst, input int cmp,
                       input bit upd, input logic [63:0] d, input logic [3:0] un,
                       input bit iss, input string tag);
        issue = iss; op = 2'(o); target = 9'(tgt); test_sel = 3'(tst);
        comp_sel = 2'(cmp); cc_wr = upd; res_data = d; res_unord = un;
        if (iss && !m_err) begin
            case (o)
                0: begin
                    if (upd)
                        for (int c = 0; c < 4; c++)
                            m_cc[c] = classify(int'($signed(d[c*16 +: 16])), un[c]);
                    m_pc = (m_pc + 1) % 512;
                end
                1: m_pc = passes(tst, m_cc[cmp]) ? tgt : (m_pc + 1) % 512;
                2: begin
                    if (!passes(tst, m_cc[cmp])) m_pc = (m_pc + 1) % 512;
                    else if (m_sp == 4) m_err = 1;
                    else begin
                        m_stk[m_sp] = (m_pc + 1) % 512;
                        m_sp++;
                        m_pc = tgt;
                    end
                end
                default: begin
                    if (m_sp == 0) m_err = 1;
                    else begin
                        m_sp--;
                        m_pc = m_stk[m_sp];
                    end
                end
            endcase
        end
        @(negedge clk);
        checks++;
        if (int'(pc) != m_pc || stack_err != m_err) begin
            fails++;
            $display("FAIL %s: pc=%0d err=%0b expected pc=%0d err=%0b",
                     tag, pc, stack_err, m_pc, m_err);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; issue = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        m_pc = 0; m_sp = 0; m_err = 0;
        for (int c = 0; c < 4; c++) m_cc[c] = 0;
    endtask

    task automatic probe_all(input string tag);
        for (int t = 0; t < 8; t++)
            for (int c = 0; c < 4; c++)
                run(1, (t * 29 + c * 7 + 3) % 512, t, c, 0, '0, '0, 1, tag);
    endtask

    initial begin
        int iters;
        logic [63:0] d;
        logic [3:0] un;
        @(negedge clk);
        do_reset();

        // R1: reset state at the ports
        check_val("R1 pc after reset", int'(pc), 0);
        check_val("R1 err after reset", int'(stack_err), 0);
        for (int c = 0; c < 4; c++) run(1, 20 + c, 2, c, 0, '0, '0, 1, "R1 eq after reset");

        // R2 / R4: every state on every component against every test
        for (int p = 0; p < 4; p++) begin
            d = '0; un = '0;
            for (int c = 0; c < 4; c++) begin
                case ((c + p) % 4)
                    0: d[c*16 +: 16] = 16'd0;
                    1: d[c*16 +: 16] = 16'(-(c + 3 + p * 1000));
                    2: d[c*16 +: 16] = 16'(100 + c + p * 5000);
                    default: begin d[c*16 +: 16] = 16'(7); un[c] = 1'b1; end
                endcase
            end
            run(0, 0, 0, 0, 1, d, un, 1, "R2 cc write");
            for (int t = 0; t < 8; t++)
                for (int c = 0; c < 4; c++)
                    run(1, (p * 97 + t * 13 + c * 5 + 7) % 512, t, c, 0, '0, '0, 1, "R4 branch test");
        end

        // R2: extreme values
        run(0, 0, 0, 0, 1, pk(-32768, 32767, 1, -1), 4'b0000, 1, "R2 extremes");
        probe_all("R2 extremes probe");

        // R3: no flag, then flow ops with the flag and data present
        run(0, 0, 0, 0, 1, pk(5, -5, 0, 9), 4'b0000, 1, "R3 setup");
        run(0, 0, 0, 0, 0, pk(-1, -1, -1, -1), 4'b1111, 1, "R3 no flag");
        run(1, 60, 1, 0, 1, pk(-1, -1, -1, -1), 4'b1111, 1, "R3 branch with flag");
        run(2, 90, 0, 0, 1, pk(-2, 0, 0, 0), 4'b0000, 1, "R3 call with flag");
        run(3, 0, 0, 0, 1, pk(0, 0, 0, 0), 4'b1111, 1, "R3 return with flag");
        probe_all("R3 cc unchanged");

        // R10: idle cycles hold everything
        run(1, 300, 0, 0, 1, pk(-9, -9, -9, -9), 4'b0000, 0, "R10 idle branch");
        run(0, 0, 0, 0, 1, pk(-9, -9, -9, -9), 4'b1111, 0, "R10 idle write");
        probe_all("R10 cc unchanged");

        // R5 / R6 / R7: nesting and LIFO order
        do_reset();
        run(2, 100, 0, 0, 0, '0, '0, 1, "R5 call 1");
        run(2, 200, 2, 1, 0, '0, '0, 1, "R5 call 2");
        run(2, 300, 0, 2, 0, '0, '0, 1, "R5 call 3");
        run(2, 50, 1, 0, 0, '0, '0, 1, "R5 untaken call");
        run(2, 50, 6, 0, 0, '0, '0, 1, "R5 untaken call gt");
        run(2, 400, 5, 3, 0, '0, '0, 1, "R7 call 4");
        run(3, 0, 1, 0, 0, '0, '0, 1, "R6 return ignores test");
        run(3, 0, 4, 2, 0, '0, '0, 1, "R7 return 3");
        run(3, 0, 0, 0, 0, '0, '0, 1, "R7 return 2");
        run(3, 0, 1, 3, 0, '0, '0, 1, "R7 return 1");
        check_val("R7 back at base", int'(pc), 1);

        // R8: underflow
        run(3, 0, 0, 0, 0, '0, '0, 1, "R8 underflow");
        check_val("R8 underflow err", int'(stack_err), 1);
        // R9: frozen
        run(1, 77, 0, 0, 0, '0, '0, 1, "R9 frozen branch");
        run(0, 0, 0, 0, 1, pk(-4, -4, -4, -4), 4'b0000, 1, "R9 frozen write");
        run(2, 88, 0, 0, 0, '0, '0, 1, "R9 frozen call");
        check_val("R9 pc frozen", int'(pc), 1);

        // R1: reset clears the error
        do_reset();
        check_val("R1 err cleared", int'(stack_err), 0);
        probe_all("R1 cc after reset");

        // R8: overflow on fifth push
        for (int k = 0; k < 4; k++) run(2, 10 + k * 10, 0, 0, 0, '0, '0, 1, "R8 fill");
        run(2, 200, 2, 0, 0, '0, '0, 1, "R8 fifth call");
        check_val("R8 overflow err", int'(stack_err), 1);
        check_val("R8 pc held", int'(pc), 40);
        run(3, 0, 0, 0, 0, '0, '0, 1, "R9 frozen return");

        // R8: a failing call into a full stack does not fault
        do_reset();
        for (int k = 0; k < 4; k++) run(2, 10 + k * 10, 0, 0, 0, '0, '0, 1, "R8 fill 2");
        run(2, 200, 1, 0, 0, '0, '0, 1, "R8 untaken call on full");
        check_val("R8 no fault", int'(stack_err), 0);

        // R11: wrap
        do_reset();
        run(1, 511, 0, 0, 0, '0, '0, 1, "R11 to 511");
        run(0, 0, 0, 0, 0, '0, '0, 1, "R11 wrap step");
        check_val("R11 wrapped", int'(pc), 0);
        run(1, 511, 0, 0, 0, '0, '0, 1, "R11 to 511 again");
        run(2, 10, 0, 0, 0, '0, '0, 1, "R11 call at 511");
        run(3, 0, 0, 0, 0, '0, '0, 1, "R11 return wrap");
        check_val("R11 return addr", int'(pc), 0);

        // R12: counted loops
        for (int n = 1; n <= 6; n++) begin
            int cnt;
            do_reset();
            run(1, 40, 0, 0, 0, '0, '0, 1, "R12 enter");
            run(0, 0, 0, 0, 1, pk(n, 0, 0, 0), 4'b0000, 1, "R12 load");
            cnt = n;
            iters = 0;
            for (int g = 0; g < 20; g++) begin
                cnt--;
                run(0, 0, 0, 0, 1, pk(cnt, 0, 0, 0), 4'b0000, 1, "R12 decrement");
                run(1, 41, 6, 0, 0, '0, '0, 1, "R12 loop branch");
                iters++;
                if (pc != 9'd41) break;
            end
            check_val("R12 iterations", iters, n);
            check_val("R12 exit pc", int'(pc), 43);
        end

        issue = 1'b0;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=expired expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule